// File: doc/BRIEF.md
# RGB to BT.656 Output Formatter

This block turns a progressive stream of 24-bit RGB pixels into the byte stream a standard-definition TV encoder expects. That stream is interlaced, multiplexed 4:2:2 YCbCr, one byte per enabled clock, with timing reference codes embedded in it. Each incoming frame yields one output field, and the field parity alternates from frame to frame. Lines of the wrong parity are dropped, so the progressive picture becomes interlaced without a frame store.

The data passes through four stages. An optional three-tap vertical flicker filter is built from two internal line buffers. A fixed-point studio-range colour converter follows it. Chroma is then averaged over each pixel pair. Last comes a packer that wraps every kept line in start and end codes and pushes the bytes into a small output queue, which drains one byte per clock.

The filter enable is taken at the start of each frame, so software may change it at any time without tearing a field.

Top module: `rgb656_formatter`

## Requirements
- R1: After reset `out_en` is low and no byte leaves the block until a kept line has been received.
- R2: The first frame after reset is output as field F=0 and keeps the zero-based even source lines. The next frame is field F=1 and keeps the odd lines. Parity then alternates on every `in_sof`, and dropped lines produce no bytes.
- R3: Each kept line is emitted as a start code, then 2·H_ACT data bytes, then an end code. Each code is the four bytes FF, 00, 00, XY, with H=0 in the start code and H=1 in the end code. V is 0 on all active lines.
- R4: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, most significant bit first.
- R5: For each pixel pair at columns 2k and 2k+1, the data bytes are sent in the order Cb, Y(2k), Cr, Y(2k+1).
- R6: For input R=`in_rgb[23:16]`, G=`in_rgb[15:8]` and B=`in_rgb[7:0]`, the converter computes Y = 16 + floor((66R+129G+25B+128)/256) clamped to 16..235, Cb = 128 + floor((−38R−74G+112B+128)/256), and Cr = 128 + floor((112R−94G−18B+128)/256). Cb and Cr are each clamped to 16..240. No data byte is ever 00 or FF.
- R7: The pair's Cb is (Cb(2k)+Cb(2k+1)+1)>>1, and the pair's Cr is formed the same way.
- R8: With the filter on, output line n is (L[n−2] + 2·L[n−1] + L[n] + 2)>>2 per colour channel, with lines above the top of the frame replaced by line 0.
- R9: With the filter off, line n passes to the converter unchanged.
- R10: `cfg_flicker_en` is sampled only with the `in_sof` pixel, and a change during a frame has no effect on that frame.
- R11: Input pixels never arrive on two consecutive cycles. Under that cadence, with dropped lines between kept lines, no output byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present on `in_rgb` |
| in_sof | input | 1 | With `in_valid`: first pixel of a frame |
| in_sol | input | 1 | With `in_valid`: first pixel of a line |
| in_rgb | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| cfg_flicker_en | input | 1 | Flicker filter enable, taken at frame start |
| out_byte | output | 8 | Multiplexed 4:2:2 byte stream |
| out_en | output | 1 | Clock enable: `out_byte` holds a byte this cycle |

## Verification
The bench targets the top two lines of each frame, where the filter must replicate line 0. A design that read stale line-buffer contents there would leak the previous frame into the new field. Saturated primaries and black/white pixels drive the converter to its clamp edges, where a logical instead of arithmetic shift, or a missing clamp, would produce wrong Cb/Cr or a reserved 00/FF byte. Frames alternate in parity and one frame flips the filter enable mid-field: a wrong field bit, wrong line selection or a live enable shows up as extra, missing or altered bytes against the scoreboard.

// File: rtl/fmt656_pkg.sv
package fmt656_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cb;
    logic [7:0] cr;
  } ycc_t;

  // one channel of the 1-2-1 vertical kernel, rounded
  function automatic logic [7:0] tap3(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] c);
    logic [9:0] s;
    s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c} + 10'd2;
    return s[9:2];
  endfunction

  function automatic rgb_t flick3(input rgb_t a, input rgb_t b, input rgb_t c);
    rgb_t o;
    o.r = tap3(a.r, b.r, c.r);
    o.g = tap3(a.g, b.g, c.g);
    o.b = tap3(a.b, b.b, c.b);
    return o;
  endfunction

  // weighted sum scaled by 1/256 with floor (arithmetic shift)
  function automatic int lin3(input rgb_t p, input int kr, input int kg, input int kb);
    int s;
    s = kr * int'(p.r) + kg * int'(p.g) + kb * int'(p.b) + 128;
    return s >>> 8;
  endfunction

  function automatic logic [7:0] clip8(input int v, input int lo, input int hi);
    logic [31:0] t;
    if (v < lo)      t = lo;
    else if (v > hi) t = hi;
    else             t = v;
    return t[7:0];
  endfunction

  function automatic ycc_t rgb2ycc(input rgb_t p);
    ycc_t o;
    o.y  = clip8(lin3(p,  66, 129,  25) +  16, 16, 235);
    o.cb = clip8(lin3(p, -38, -74, 112) + 128, 16, 240);
    o.cr = clip8(lin3(p, 112, -94, -18) + 128, 16, 240);
    return o;
  endfunction

  function automatic logic [7:0] avg2(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  function automatic logic [7:0] xy_code(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/fmt656_linebuf.sv
module fmt656_linebuf
  import fmt656_pkg::*;
#(
  parameter int H_ACT = 720,
  parameter int CW    = $clog2(H_ACT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          px_valid,
  input  logic [23:0]   px_rgb,
  input  logic [CW-1:0] px_col,
  input  logic          top_line,
  input  logic          second_line,
  input  logic          flk_en,
  input  logic          keep,
  input  logic          fld,
  input  logic          last_col,
  output logic          s1_vld,
  output rgb_t          s1_rgb,
  output logic          s1_first,
  output logic          s1_last,
  output logic          s1_odd,
  output logic          s1_fld
);

  rgb_t lb_near [H_ACT];
  rgb_t lb_far  [H_ACT];

  rgb_t cur, near_px, far_px, tap_a, tap_b, filt;

  always_comb begin
    cur     = rgb_t'(px_rgb);
    near_px = lb_near[px_col];
    far_px  = lb_far[px_col];
    tap_b   = top_line ? cur : near_px;
    tap_a   = top_line ? cur : (second_line ? near_px : far_px);
    filt    = flk_en ? flick3(tap_a, tap_b, cur) : cur;
  end

  always_ff @(posedge clk) begin
    if (px_valid) begin
      lb_near[px_col] <= cur;
      lb_far[px_col]  <= near_px;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_rgb   <= '0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_odd   <= 1'b0;
      s1_fld   <= 1'b0;
    end else begin
      s1_vld <= px_valid && keep;
      if (px_valid) begin
        s1_rgb   <= filt;
        s1_first <= (px_col == '0);
        s1_last  <= last_col;
        s1_odd   <= px_col[0];
        s1_fld   <= fld;
      end
    end
  end

  // R2: a kept pixel always carries the parity of its own field
  a_r2_kept_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && keep && top_line) |-> !fld)
    else $error("a_r2_kept_parity");

endmodule

// File: rtl/fmt656_csc.sv
module fmt656_csc
  import fmt656_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s1_vld,
  input  rgb_t s1_rgb,
  input  logic s1_first,
  input  logic s1_last,
  input  logic s1_odd,
  input  logic s1_fld,
  output logic s2_vld,
  output ycc_t s2_ycc,
  output logic s2_first,
  output logic s2_last,
  output logic s2_odd,
  output logic s2_fld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_ycc   <= '0;
      s2_first <= 1'b0;
      s2_last  <= 1'b0;
      s2_odd   <= 1'b0;
      s2_fld   <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_ycc   <= rgb2ycc(s1_rgb);
        s2_first <= s1_first;
        s2_last  <= s1_last;
        s2_odd   <= s1_odd;
        s2_fld   <= s1_fld;
      end
    end
  end

  // R6: converted samples stay inside studio range
  a_r6_ycc_range: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> (s2_ycc.y >= 8'd16 && s2_ycc.y <= 8'd235 &&
                s2_ycc.cb >= 8'd16 && s2_ycc.cb <= 8'd240 &&
                s2_ycc.cr >= 8'd16 && s2_ycc.cr <= 8'd240))
    else $error("a_r6_ycc_range");

endmodule

// File: rtl/fmt656_pack.sv
module fmt656_pack
  import fmt656_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s2_vld,
  input  ycc_t        s2_ycc,
  input  logic        s2_first,
  input  logic        s2_last,
  input  logic        s2_odd,
  input  logic        s2_fld,
  output logic        push,
  output logic [31:0] push_word
);

  logic [7:0] y0_q, cb0_q, cr0_q;
  logic       even_held, eav_pend, eav_fld;
  logic       ev_sav, ev_pair, ev_eav;

  always_comb begin
    ev_sav  = s2_vld && s2_first;
    ev_pair = s2_vld && s2_odd;
    ev_eav  = eav_pend;
    push    = ev_sav || ev_pair || ev_eav;
    if (ev_eav)
      push_word = {8'hFF, 8'h00, 8'h00, xy_code(eav_fld, 1'b0, 1'b1)};
    else if (ev_pair)
      push_word = {avg2(cb0_q, s2_ycc.cb), y0_q, avg2(cr0_q, s2_ycc.cr), s2_ycc.y};
    else if (ev_sav)
      push_word = {8'hFF, 8'h00, 8'h00, xy_code(s2_fld, 1'b0, 1'b0)};
    else
      push_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y0_q      <= '0;
      cb0_q     <= '0;
      cr0_q     <= '0;
      even_held <= 1'b0;
      eav_pend  <= 1'b0;
      eav_fld   <= 1'b0;
    end else begin
      eav_pend <= ev_pair && s2_last;
      if (ev_pair) eav_fld <= s2_fld;
      if (s2_vld && !s2_odd) begin
        y0_q      <= s2_ycc.y;
        cb0_q     <= s2_ycc.cb;
        cr0_q     <= s2_ycc.cr;
        even_held <= 1'b1;
      end else if (ev_pair) begin
        even_held <= 1'b0;
      end
    end
  end

  // R5: a pair is only formed after its even pixel was captured
  a_r5_pair_has_even: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair |-> even_held)
    else $error("a_r5_pair_has_even");

  // R3: an end code directly follows the last pair of a line
  a_r3_eav_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eav |-> $past(ev_pair))
    else $error("a_r3_eav_after_pair");

  // R3: the end code slot never coincides with a new pixel
  a_r3_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eav |-> !s2_vld)
    else $error("a_r3_no_collision");

  // R4: code words carry the preamble and consistent protection bits
  a_r4_xy_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sav || ev_eav) |-> (push_word[31:8] == 24'hFF0000 && push_word[7] &&
                            push_word[0] == ^push_word[6:4] && !(^push_word[3:1])))
    else $error("a_r4_xy_parity");

  // R6: no reserved value appears among data bytes
  a_r6_data_range: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair |-> (push_word[31:24] != 8'h00 && push_word[31:24] != 8'hFF &&
                 push_word[23:16] != 8'h00 && push_word[23:16] != 8'hFF &&
                 push_word[15:8]  != 8'h00 && push_word[15:8]  != 8'hFF &&
                 push_word[7:0]   != 8'h00 && push_word[7:0]   != 8'hFF))
    else $error("a_r6_data_range");

endmodule

// File: rtl/fmt656_bytefifo.sv
module fmt656_bytefifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [31:0] push_word,
  output logic [7:0]  out_byte,
  output logic        out_en
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FOUR      = (AW+1)'(4);
  localparam logic [AW:0] ONE       = (AW+1)'(1);
  localparam logic [AW:0] CNT_LIMIT = (AW+1)'(DEPTH - 4);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;
  logic [AW-1:0] waddr [4];

  assign pop = (cnt != '0);

  for (genvar k = 0; k < 4; k++) begin : g_addr
    assign waddr[k] = wp + AW'(k);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      for (int k = 0; k < 4; k++) mem[waddr[k]] <= push_word[31-8*k -: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      out_en   <= 1'b0;
      out_byte <= '0;
    end else begin
      out_en <= pop;
      if (pop) begin
        out_byte <= mem[rp];
        rp       <= rp + 1'b1;
      end
      if (push) wp <= wp + AW'(4);
      cnt <= cnt + (push ? FOUR : '0) - (pop ? ONE : '0);
    end
  end

  // R11: a push always finds room for four bytes
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt <= CNT_LIMIT))
    else $error("a_r11_no_overflow");

endmodule

// File: rtl/rgb656_formatter.sv
module rgb656_formatter #(
  parameter int H_ACT      = 720,
  parameter int V_ACT      = 480,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_sol,
  input  logic [23:0] in_rgb,
  input  logic        cfg_flicker_en,
  output logic [7:0]  out_byte,
  output logic        out_en
);
  import fmt656_pkg::*;

  localparam int CW = $clog2(H_ACT);
  localparam int LW = $clog2(V_ACT);
  localparam logic [CW-1:0] LAST_COL = CW'(H_ACT - 1);

  logic [CW-1:0] col_q, col_now;
  logic [LW-1:0] line_q, line_now;
  logic          fld_q, fld_now, flk_q, flk_now;
  logic          keep_now, last_now, top_now, second_now;

  always_comb begin
    col_now    = in_sol ? '0 : col_q + 1'b1;
    line_now   = in_sof ? '0 : (in_sol ? line_q + 1'b1 : line_q);
    fld_now    = in_sof ? ~fld_q : fld_q;
    flk_now    = in_sof ? cfg_flicker_en : flk_q;
    keep_now   = (line_now[0] == fld_now);
    last_now   = (col_now == LAST_COL);
    top_now    = (line_now == '0);
    second_now = (line_now == LW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
      fld_q  <= 1'b1;
      flk_q  <= 1'b0;
    end else if (in_valid) begin
      col_q  <= col_now;
      line_q <= line_now;
      fld_q  <= fld_now;
      flk_q  <= flk_now;
    end
  end

  logic s1_vld, s1_first, s1_last, s1_odd, s1_fld;
  rgb_t s1_rgb;
  logic s2_vld, s2_first, s2_last, s2_odd, s2_fld;
  ycc_t s2_ycc;
  logic        push;
  logic [31:0] push_word;

  fmt656_linebuf #(.H_ACT(H_ACT), .CW(CW)) u_lb (
    .clk         (clk),
    .rst_n       (rst_n),
    .px_valid    (in_valid),
    .px_rgb      (in_rgb),
    .px_col      (col_now),
    .top_line    (top_now),
    .second_line (second_now),
    .flk_en      (flk_now),
    .keep        (keep_now),
    .fld         (fld_now),
    .last_col    (last_now),
    .s1_vld      (s1_vld),
    .s1_rgb      (s1_rgb),
    .s1_first    (s1_first),
    .s1_last     (s1_last),
    .s1_odd      (s1_odd),
    .s1_fld      (s1_fld)
  );

  fmt656_csc u_csc (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_vld   (s1_vld),
    .s1_rgb   (s1_rgb),
    .s1_first (s1_first),
    .s1_last  (s1_last),
    .s1_odd   (s1_odd),
    .s1_fld   (s1_fld),
    .s2_vld   (s2_vld),
    .s2_ycc   (s2_ycc),
    .s2_first (s2_first),
    .s2_last  (s2_last),
    .s2_odd   (s2_odd),
    .s2_fld   (s2_fld)
  );

  fmt656_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .s2_vld    (s2_vld),
    .s2_ycc    (s2_ycc),
    .s2_first  (s2_first),
    .s2_last   (s2_last),
    .s2_odd    (s2_odd),
    .s2_fld    (s2_fld),
    .push      (push),
    .push_word (push_word)
  );

  fmt656_bytefifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_word (push_word),
    .out_byte  (out_byte),
    .out_en    (out_en)
  );

  // R11: pixels arrive at most every other cycle
  a_r11_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid)
    else $error("a_r11_cadence");

  // R10: the filter setting only moves with a frame start
  a_r10_flk_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(flk_q))
    else $error("a_r10_flk_held");

  // R2: each frame start flips the field parity
  a_r2_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (fld_q != $past(fld_q)))
    else $error("a_r2_field_flip");

endmodule

// File: tb/sim_rgb656_formatter.sv
module sim_rgb656_formatter;

  localparam int BH = 8;
  localparam int BV = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [23:0] in_rgb = '0;
  logic       cfg = 1'b0;
  logic [7:0] out_byte;
  logic       out_en;

  always #10 clk = ~clk;

  rgb656_formatter #(.H_ACT(BH), .V_ACT(BV), .FIFO_DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_sol(in_sol), .in_rgb(in_rgb), .cfg_flicker_en(cfg),
    .out_byte(out_byte), .out_en(out_en)
  );

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  bit   fld_m = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [23:0] img [BV][BH];

  function automatic int fl256(input int v);
    if (v >= 0) return v / 256;
    return -((-v + 255) / 256);
  endfunction
  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction
  function automatic int chan(input logic [23:0] p, input int k);
    return int'(p[8*k +: 8]);
  endfunction
  // filtered (or passed) pixel of source line n, column c (R8, R9)
  function automatic logic [23:0] src_px(input int n, input int c, input bit flk);
    logic [23:0] a, b, cc, o;
    int na, nb;
    cc = img[n][c];
    if (!flk) return cc;
    na = (n >= 2) ? n - 2 : 0;
    nb = (n >= 1) ? n - 1 : 0;
    a = img[na][c];
    b = img[nb][c];
    for (int k = 0; k < 3; k++) o[8*k +: 8] = 8'((chan(a,k) + 2*chan(b,k) + chan(cc,k) + 2) / 4);
    return o;
  endfunction
  function automatic int m_y(input logic [23:0] p);
    return lim(16 + fl256(66*chan(p,2) + 129*chan(p,1) + 25*chan(p,0) + 128), 16, 235);
  endfunction
  function automatic int m_cb(input logic [23:0] p);
    return lim(128 + fl256(-38*chan(p,2) - 74*chan(p,1) + 112*chan(p,0) + 128), 16, 240);
  endfunction
  function automatic int m_cr(input logic [23:0] p);
    return lim(128 + fl256(112*chan(p,2) - 94*chan(p,1) - 18*chan(p,0) + 128), 16, 240);
  endfunction
  function automatic logic [7:0] m_xy(input bit f, input bit h);
    logic [7:0] x;
    x = 8'h80;
    if (f) x = x | 8'h40;
    if (h) x = x | 8'h10;
    x[3] = h; x[2] = f ^ h; x[1] = f; x[0] = f ^ h;
    return x;
  endfunction

  task automatic expect_b(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic expect_line(input int n, input bit f, input bit flk, input string mode);
    logic [23:0] p0, p1;
    expect_b(8'hFF, "R3 start preamble");
    expect_b(8'h00, "R3 start preamble");
    expect_b(8'h00, "R3 start preamble");
    expect_b(m_xy(f, 1'b0), "R2 R4 start XY");
    for (int c = 0; c < BH; c += 2) begin
      p0 = src_px(n, c, flk);
      p1 = src_px(n, c + 1, flk);
      expect_b(8'((m_cb(p0) + m_cb(p1) + 1) / 2), {"R5 R7 Cb ", mode});
      expect_b(8'(m_y(p0)), {"R5 R6 Y0 ", mode});
      expect_b(8'((m_cr(p0) + m_cr(p1) + 1) / 2), {"R5 R7 Cr ", mode});
      expect_b(8'(m_y(p1)), {"R5 R6 Y1 ", mode});
    end
    expect_b(8'hFF, "R3 end preamble");
    expect_b(8'h00, "R3 end preamble");
    expect_b(8'h00, "R3 end preamble");
    expect_b(m_xy(f, 1'b1), "R2 R4 end XY");
  endtask

  function automatic logic [23:0] pick(input int pat, input int r, input int c);
    logic [23:0] sat [8];
    sat[0] = 24'hFFFFFF; sat[1] = 24'h000000; sat[2] = 24'hFF0000; sat[3] = 24'h00FF00;
    sat[4] = 24'h0000FF; sat[5] = 24'hFFFF00; sat[6] = 24'h00FFFF; sat[7] = 24'hFF00FF;
    case (pat)
      0:       return {8'(r*40 + c*7), 8'(255 - c*30), 8'(r*c*13)};
      2:       return sat[(r + c) % 8];
      default: return 24'($urandom);
    endcase
  endfunction

  // drive one frame; flip_mid toggles the enable after the frame start (R10)
  task automatic run_frame(input int pat, input bit flk, input bit flip_mid, input string mode);
    for (int r = 0; r < BV; r++)
      for (int c = 0; c < BH; c++) img[r][c] = pick(pat, r, c);
    for (int r = 0; r < BV; r++)
      if ((r % 2) == int'(fld_m)) expect_line(r, fld_m, flk, mode);
    @(negedge clk);
    cfg = flk;
    for (int r = 0; r < BV; r++) begin
      for (int c = 0; c < BH; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_sol   = (c == 0);
        in_rgb   = img[r][c];
        if (flip_mid && r == 2 && c == 3) cfg = ~cfg;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        if (pat == 1 && (c % 3) == 1) @(negedge clk);
      end
      repeat (3) @(negedge clk);
    end
    fld_m = ~fld_m;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_en) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R2 R3 unexpected byte: actual %02h expected none", out_byte);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_byte !== e) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", t, out_byte, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (out_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 out_en in reset: actual %b expected 0", out_en);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    n_chk++;
    if (out_en !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 out_en idle after reset: actual %b expected 0", out_en);
    end
    run_frame(0, 1'b1, 1'b0, "R8 ramp");
    run_frame(1, 1'b1, 1'b0, "R8 random");
    run_frame(2, 1'b0, 1'b0, "R9 saturated");
    run_frame(2, 1'b1, 1'b0, "R8 saturated");
    run_frame(1, 1'b0, 1'b1, "R10 off then toggled");
    run_frame(0, 1'b1, 1'b1, "R10 on then toggled");
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 bytes lost: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule